// File: doc/BRIEF.md
# Byte Table Lookup Unit

The unit builds a 32-bit result from four separate byte lookups into a small table of 64-bit words. Software or a neighbouring block loads the table one word at a time through a write port. Each byte of a 32-bit index word is treated as an index into the table. The index selects one byte out of the words that have been loaded.

When a lane's index is not below a programmable limit, that lane of the result does not return zero. It copies the byte in the same position of a default word that the caller supplies. The caller pulses a request strobe together with the index word, the default word and the limit. The registered result then appears one cycle later with a valid strobe.

Top module: `tbl_lookup`

## Requirements
- R1: After a synchronous active-low reset, `res_vld` is 0 and `res_data` is 0.
- R2: `res_vld` is 1 in the cycle after a cycle with `req_vld` high, and is 0 in the cycle after a cycle with `req_vld` low.
- R3: The index word is split into four 8-bit lane indices: lane k is bits [8k+7:8k], for k = 0 to 3. Each lane is resolved on its own, and its result goes back into bits [8k+7:8k] of `res_data`.
- R4: A lane index is in range only when it is strictly less than `req_limit`. In that case, index bits [7:3] name the table word and index bits [2:0] name the byte within that word. Byte 0 is bits [7:0] of the word.
- R5: A lane whose index is greater than or equal to `req_limit` takes bits [8k+7:8k] of `req_dflt`. This includes every index of 32 or above.
- R6: `req_limit` is one of 8, 16, 24 or 32. These values enable one to four table words.
- R7: A write with `wr_en` high stores `wr_data` into table word `wr_addr` (2 bits). A lookup in the same cycle uses the table contents from before that write.
- R8: When `req_vld` is low, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 2 | Table word address |
| wr_data | input | 64 | Table word data |
| req_vld | input | 1 | Lookup request strobe |
| req_idx | input | 32 | Four 8-bit lane indices |
| req_dflt | input | 32 | Default bytes for out-of-range lanes |
| req_limit | input | 6 | Index limit (8, 16, 24 or 32) |
| res_vld | output | 1 | Result valid, one cycle after request |
| res_data | output | 32 | Assembled lookup result |

## Verification
A corrupted table word appears only in lanes whose index points into that word. It shows one cycle after such a request, in exactly the byte the index names. A wrong range compare shows at the boundary indices `limit-1` and `limit` as default bytes in the wrong lanes. A stale or early write shows as the old or new word in a lookup issued in the same cycle as the write. All of these are visible at `res_data` in the cycle after the request.

// File: rtl/tbl_lookup_pkg.sv
// Package: shared widths and the lane type for the byte table lookup unit.
package tbl_lookup_pkg;
    localparam int LANE_W   = 8;
    localparam int BYTE_SEL = 3;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/tbl_store.sv
// Table storage: WORDS registers of WORD_W bits, written one word per cycle.
// Assumes the read side accepts registered contents, so a lookup in the same
// cycle as a write sees the old word.
module tbl_store #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [WORDS-1:0][WORD_W-1:0]  words
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Hold one word; clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (wr_en && wr_addr == AW'(w))
                words[w] <= wr_data;
        end
    end
endmodule

// File: rtl/tbl_lane.sv
// One lane resolver: picks a byte from the table for an in-range index,
// or returns the default byte. Pure combinational logic.
module tbl_lane
    import tbl_lookup_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    parameter int LIM_W  = 6,
    localparam int BPW   = WORD_W / LANE_W
) (
    input  logic [WORDS-1:0][WORD_W-1:0] words,
    input  lane_t                        idx,
    input  lane_t                        dflt,
    input  logic [LIM_W-1:0]             limit,
    output lane_t                        sel
);
    logic                     in_range;
    logic [LANE_W-BYTE_SEL-1:0] word_sel;
    logic [BYTE_SEL-1:0]      byte_sel;
    logic [WORD_W-1:0]        word_val;

    // Decode the index and choose either the table byte or the default byte.
    always_comb begin
        in_range = {1'b0, idx} < {{(LANE_W+1-LIM_W){1'b0}}, limit};
        word_sel = idx[LANE_W-1:BYTE_SEL];
        byte_sel = idx[BYTE_SEL-1:0];
        word_val = '0;
        for (int w = 0; w < WORDS; w++)
            if (word_sel == (LANE_W-BYTE_SEL)'(w)) word_val = words[w];
        sel = in_range ? word_val[byte_sel*LANE_W +: LANE_W] : dflt;
    end

    // A byte position inside a word is always within the word.
    initial assert (BPW == (1 << BYTE_SEL));
endmodule

// File: rtl/tbl_lookup.sv
// Byte table lookup unit top. Four lanes are resolved in parallel against the
// table, and the result is registered with a valid strobe one cycle after the
// request. Assumes req_limit is a multiple of 8 from 8 to 32.
module tbl_lookup
    import tbl_lookup_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    parameter int LANES  = 4,
    parameter int LIM_W  = 6,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              req_vld,
    input  logic [DW-1:0]     req_idx,
    input  logic [DW-1:0]     req_dflt,
    input  logic [LIM_W-1:0]  req_limit,
    output logic              res_vld,
    output logic [DW-1:0]     res_data
);
    logic [WORDS-1:0][WORD_W-1:0] words;
    logic [DW-1:0]                lane_res;

    tbl_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .words(words)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tbl_lane #(.WORDS(WORDS), .WORD_W(WORD_W), .LIM_W(LIM_W)) u_lane (
            .words(words),
            .idx  (req_idx[k*LANE_W +: LANE_W]),
            .dflt (req_dflt[k*LANE_W +: LANE_W]),
            .limit(req_limit),
            .sel  (lane_res[k*LANE_W +: LANE_W])
        );
    end

    // Register the assembled result and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_data <= '0;
        end else begin
            res_vld <= req_vld;
            if (req_vld) res_data <= lane_res;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && res_data == '0));
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> $stable(res_data));
    assert_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> (req_limit[2:0] == 3'd0 && req_limit >= 6'd8 && req_limit <= 6'd32));
    assert_dflt_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && {1'b0, req_idx[7:0]} >= {3'b0, req_limit})
        |=> res_data[7:0] == $past(req_dflt[7:0]));
endmodule

// File: tb/tbl_lookup_bench.sv
module tbl_lookup_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [63:0] wr_data = 0;
    logic        req_vld = 0;
    logic [31:0] req_idx = 0;
    logic [31:0] req_dflt = 0;
    logic [5:0]  req_limit = 6'd32;
    logic        res_vld;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] mdl [4];

    always #2 clk = ~clk;

    tbl_lookup u_tbl_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_vld(req_vld), .req_idx(req_idx),
        .req_dflt(req_dflt), .req_limit(req_limit),
        .res_vld(res_vld), .res_data(res_data)
    );

    function automatic logic [31:0] expect_res(logic [31:0] idx, logic [31:0] dflt,
                                               logic [5:0] lim);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ix;
            ix = idx[k*8 +: 8];
            if (ix < {2'b0, lim}) r[k*8 +: 8] = mdl[ix[4:3]][ix[2:0]*8 +: 8];
            else                  r[k*8 +: 8] = dflt[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [1:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        mdl[a] = d;
    endtask

    // Issue one lookup and compare the result one cycle later.
    task automatic lookup(string req, logic [31:0] idx, logic [31:0] dflt,
                          logic [5:0] lim);
        logic [31:0] e;
        @(negedge clk);
        req_vld = 1; req_idx = idx; req_dflt = dflt; req_limit = lim;
        e = expect_res(idx, dflt, lim);
        @(negedge clk);
        req_vld = 0;
        check("R2", {31'b0, res_vld}, 32'd1);
        check(req, res_data, e);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R1", {31'b0, res_vld}, 32'd0);
        check("R1", res_data, 32'd0);
        rst_n = 1;
        write_word(2'd0, 64'h0706050403020100);
        write_word(2'd1, 64'h1716151413121110);
        write_word(2'd2, 64'hA7A6A5A4A3A2A1A0);
        write_word(2'd3, 64'hF7F6F5F4F3F2F1F0);
        // R3 lane placement and R4 word/byte select
        lookup("R3", 32'h1F100700, 32'hDEADBEEF, 6'd32);
        lookup("R4", 32'h09131A0F, 32'h0, 6'd32);
        // R5 boundary: limit-1 in range, limit uses default
        lookup("R5", 32'h0F101520, 32'hCAFEF00D, 6'd16);
        lookup("R5", 32'hFF200807, 32'h11223344, 6'd8);
        // R6 each limit
        lookup("R6", 32'h17181F10, 32'h55667788, 6'd24);
        lookup("R6", 32'h1F1E2021, 32'h99AABBCC, 6'd32);
        // R8 hold without request
        held = res_data;
        @(negedge clk);
        req_idx = 32'h01020304;
        @(negedge clk);
        check("R8", res_data, held);
        check("R2", {31'b0, res_vld}, 32'd0);
        // R7 write and lookup in same cycle see old word
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 64'h0123456789ABCDEF;
        req_vld = 1; req_idx = 32'h08090A0B; req_dflt = 0; req_limit = 6'd32;
        e = expect_res(32'h08090A0B, 0, 6'd32);
        @(negedge clk);
        wr_en = 0; req_vld = 0; mdl[1] = 64'h0123456789ABCDEF;
        check("R7", res_data, e);
        lookup("R7", 32'h08090A0B, 32'h0, 6'd32);
        // Random mix
        for (int i = 0; i < 200; i++) begin
            if ($urandom % 4 == 0)
                write_word(2'($urandom), {$urandom, $urandom});
            lookup("R4", $urandom & 32'h3F3F3F3F, $urandom, 6'(8 * (1 + $urandom % 4)));
        end
        // Reset again
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1", res_data, 32'd0);
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        lookup("R1", 32'h00081018, 32'h0, 6'd32);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule